// File: doc/BRIEF.md
# Interruption Entry Sequencer

This block carries out, in hardware, the fixed set of state changes a processor core makes at the moment it accepts an interruption. A pending interruption arrives as a request with a 5-bit vector number and a flag marking it as a high-priority machine check.

When the request is taken, four things happen on one clock edge:

- The live status word is copied whole into an interruption status register.
- A new status word is forced.
- Seven designated general registers, presented on a flat input bus, are captured into shadow registers.
- A one-cycle redirect strobe is raised to instruction fetch, together with the handler address. That address is the vector base plus 32 bytes per vector number.

Software can write the status word and the vector base register. The base register keeps its low ten bits at zero, so the 32-slot table of 32-byte slots stays aligned. Because entry clears the interrupt-enable bit, a maskable request is refused until software writes a status word with that bit set again. A machine check is taken regardless, which lets it nest.

Top module: `trap_entry_ctl`

## Requirements
- R1: After synchronous reset, the status word, the saved status, the vector base and all shadows are zero, and the redirect strobe is low.
- R2: On an accepted interruption, the saved status register receives the complete status word as it stood in the cycle before the entry edge.
- R3: The entry status word has every bit zero except two: endian bit 4 takes the parameter DEF_ENDIAN, and bit 5 (M) is 1 only for a machine check. The named bits are I bit 0, Q bit 1, C bit 2, D bit 3, and privilege bits 7:6.
- R4: The seven shadow outputs equal the seven general register inputs sampled on the accepting edge. Word k sits at bits 32k+31:32k.
- R5: The redirect strobe is high for exactly the cycle after the accepting edge, with a target of vector base + 32 × vector number for vector numbers 0 to 31.
- R6: A vector base write stores the written value with bits 9:0 forced to zero, visible one cycle later.
- R7: A maskable request (machine-check flag 0) while status bit I is 0 is ignored: no redirect occurs, and the status word and saved status stay unchanged.
- R8: A machine-check request is accepted even when status bit I is 0.
- R9: A software status write takes effect one cycle later, and writing I = 1 lets the next maskable request be accepted.
- R10: When a software status write and an accepted interruption fall on the same edge, the entry wins. The saved status receives the pre-write status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interruption pending |
| irq_hpmc_i | input | 1 | Pending interruption is a high-priority machine check |
| irq_vec_i | input | 5 | Vector number 0..31 |
| gr_i | input | 224 | The seven designated general registers, word k at bits 32k+31:32k |
| psw_wr_en_i | input | 1 | Software status word write |
| psw_wr_data_i | input | 32 | Status word write value |
| vba_wr_en_i | input | 1 | Vector base write |
| vba_wr_data_i | input | 32 | Vector base write value |
| psw_o | output | 32 | Current status word |
| ipsw_o | output | 32 | Saved status word |
| vba_o | output | 32 | Vector base |
| shadow_o | output | 224 | Shadow register contents |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Handler address |

## Verification
Maskable requests are issued both with the enable bit set and with it cleared, so acceptance and refusal are told apart by the presence of a redirect and by whether the status registers hold still. Machine checks are sent while the enable bit is clear, which separates the machine-check bypass and the M bit from the maskable path. Vector numbers 0, 1, 17 and 31 are tried against bases written with dirty low bits, exposing errors in slot scaling and alignment. A status write landing on the same edge as an entry shows which of the two updates wins. Distinct register patterns on each entry catch shadow words that are swapped or stale.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int XLEN       = 32;
    localparam int VEC_W      = 5;
    localparam int SLOT_SHIFT = 5;
    localparam int ALIGN_W    = VEC_W + SLOT_SHIFT;

    // Status word layout; field order fixes the bit positions.
    typedef struct packed {
        logic [23:0] rsvd;
        logic [1:0]  priv;
        logic        m;
        logic        e;
        logic        d;
        logic        c;
        logic        q;
        logic        i;
    } stat_t;

    typedef struct packed {
        logic             fire;
        logic             hpmc;
        logic [VEC_W-1:0] vec;
    } accept_t;

    function automatic stat_t entry_status(input logic endian, input logic hpmc);
        stat_t s;
        s      = '0;
        s.e    = endian;
        s.m    = hpmc;
        return s;
    endfunction

    function automatic logic [XLEN-1:0] slot_addr(input logic [XLEN-1:0] base,
                                                  input logic [VEC_W-1:0] vec);
        return base + (XLEN'(vec) << SLOT_SHIFT);
    endfunction

endpackage

// File: rtl/trap_accept.sv
module trap_accept
    import trap_entry_pkg::*;
(
    input  logic             req,
    input  logic             hpmc,
    input  logic [VEC_W-1:0] vec,
    input  stat_t            cur,
    output accept_t          acc
);
    always_comb begin
        acc.fire = req && (hpmc || cur.i);
        acc.hpmc = hpmc;
        acc.vec  = vec;
    end
endmodule

// File: rtl/trap_status.sv
module trap_status
    import trap_entry_pkg::*;
#(
    parameter logic DEF_ENDIAN = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  accept_t         acc,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output stat_t           cur,
    output stat_t           saved
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            saved <= '0;
        end else if (acc.fire) begin
            saved <= cur;
            cur   <= entry_status(DEF_ENDIAN, acc.hpmc);
        end else if (wr_en) begin
            cur   <= stat_t'(wr_data);
        end
    end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_entry_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  accept_t         acc,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] base,
    output logic            redirect,
    output logic [XLEN-1:0] target
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (wr_en) begin
            base <= {wr_data[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect <= 1'b0;
            target   <= '0;
        end else begin
            redirect <= acc.fire;
            if (acc.fire) begin
                target <= slot_addr(base, acc.vec);
            end
        end
    end
endmodule

// File: rtl/trap_shadow.sv
module trap_shadow #(
    parameter int GR_W       = 32,
    parameter int NUM_SHADOW = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       capture,
    input  logic [GR_W*NUM_SHADOW-1:0] gr,
    output logic [GR_W*NUM_SHADOW-1:0] shadow
);
    for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[k*GR_W +: GR_W] <= '0;
            end else if (capture) begin
                shadow[k*GR_W +: GR_W] <= gr[k*GR_W +: GR_W];
            end
        end
    end
endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
    import trap_entry_pkg::*;
#(
    parameter logic DEF_ENDIAN = 1'b1,
    parameter int   GR_W       = 32,
    parameter int   NUM_SHADOW = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       irq_req_i,
    input  logic                       irq_hpmc_i,
    input  logic [VEC_W-1:0]           irq_vec_i,
    input  logic [GR_W*NUM_SHADOW-1:0] gr_i,
    input  logic                       psw_wr_en_i,
    input  logic [XLEN-1:0]            psw_wr_data_i,
    input  logic                       vba_wr_en_i,
    input  logic [XLEN-1:0]            vba_wr_data_i,
    output logic [XLEN-1:0]            psw_o,
    output logic [XLEN-1:0]            ipsw_o,
    output logic [XLEN-1:0]            vba_o,
    output logic [GR_W*NUM_SHADOW-1:0] shadow_o,
    output logic                       redirect_o,
    output logic [XLEN-1:0]            redirect_pc_o
);
    stat_t   cur_s;
    stat_t   saved_s;
    accept_t acc;

    trap_accept u_accept (
        .req  (irq_req_i),
        .hpmc (irq_hpmc_i),
        .vec  (irq_vec_i),
        .cur  (cur_s),
        .acc  (acc)
    );

    trap_status #(.DEF_ENDIAN(DEF_ENDIAN)) u_status (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wr_en   (psw_wr_en_i),
        .wr_data (psw_wr_data_i),
        .cur     (cur_s),
        .saved   (saved_s)
    );

    trap_vector u_vector (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wr_en    (vba_wr_en_i),
        .wr_data  (vba_wr_data_i),
        .base     (vba_o),
        .redirect (redirect_o),
        .target   (redirect_pc_o)
    );

    trap_shadow #(.GR_W(GR_W), .NUM_SHADOW(NUM_SHADOW)) u_shadow (
        .clk     (clk),
        .rst     (rst),
        .capture (acc.fire),
        .gr      (gr_i),
        .shadow  (shadow_o)
    );

    assign psw_o  = cur_s;
    assign ipsw_o = saved_s;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
    import trap_entry_pkg::*;
#(
    parameter logic DEF_ENDIAN = 1'b1,
    parameter int   SW         = 224
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_req_i,
    input logic            irq_hpmc_i,
    input logic [VEC_W-1:0] irq_vec_i,
    input logic [SW-1:0]   gr_i,
    input logic            vba_wr_en_i,
    input logic [XLEN-1:0] vba_wr_data_i,
    input logic [XLEN-1:0] psw_o,
    input logic [XLEN-1:0] ipsw_o,
    input logic [XLEN-1:0] vba_o,
    input logic [SW-1:0]   shadow_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o
);
    // R2
    ipsw_save_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> ipsw_o == $past(psw_o));

    // R3
    entry_psw_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> (psw_o[31:6] == '0 && psw_o[3:0] == '0 && psw_o[4] == DEF_ENDIAN));

    // R4
    shadow_cap_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> shadow_o == $past(gr_i));

    // R5
    target_addr_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |-> redirect_pc_o == $past(vba_o) + (XLEN'($past(irq_vec_i)) << SLOT_SHIFT));

    // R6
    vba_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(vba_wr_en_i)) |->
        (vba_o[XLEN-1:ALIGN_W] == $past(vba_wr_data_i[XLEN-1:ALIGN_W]) && vba_o[ALIGN_W-1:0] == '0));

    // R7
    mask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_req_i && !irq_hpmc_i && !psw_o[0])) |-> !redirect_o);

    // R8
    hpmc_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(irq_req_i && irq_hpmc_i)) |-> (redirect_o && psw_o[5]));
endmodule

bind trap_entry_ctl trap_entry_chk #(.DEF_ENDIAN(DEF_ENDIAN), .SW(GR_W*NUM_SHADOW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .irq_req_i     (irq_req_i),
    .irq_hpmc_i    (irq_hpmc_i),
    .irq_vec_i     (irq_vec_i),
    .gr_i          (gr_i),
    .vba_wr_en_i   (vba_wr_en_i),
    .vba_wr_data_i (vba_wr_data_i),
    .psw_o         (psw_o),
    .ipsw_o        (ipsw_o),
    .vba_o         (vba_o),
    .shadow_o      (shadow_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
);

// File: tb/test_trap_entry_ctl.sv
module test_trap_entry_ctl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         irq_req_i = 1'b0;
    logic         irq_hpmc_i = 1'b0;
    logic [4:0]   irq_vec_i = '0;
    logic [223:0] gr_i = '0;
    logic         psw_wr_en_i = 1'b0;
    logic [31:0]  psw_wr_data_i = '0;
    logic         vba_wr_en_i = 1'b0;
    logic [31:0]  vba_wr_data_i = '0;
    logic [31:0]  psw_o, ipsw_o, vba_o, redirect_pc_o;
    logic [223:0] shadow_o;
    logic         redirect_o;

    always #10 clk = ~clk;

    trap_entry_ctl i_trap_entry_ctl (
        .clk(clk), .rst(rst),
        .irq_req_i(irq_req_i), .irq_hpmc_i(irq_hpmc_i), .irq_vec_i(irq_vec_i),
        .gr_i(gr_i),
        .psw_wr_en_i(psw_wr_en_i), .psw_wr_data_i(psw_wr_data_i),
        .vba_wr_en_i(vba_wr_en_i), .vba_wr_data_i(vba_wr_data_i),
        .psw_o(psw_o), .ipsw_o(ipsw_o), .vba_o(vba_o), .shadow_o(shadow_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    typedef struct {
        logic [31:0]  pc;
        logic [31:0]  ipsw;
        logic [31:0]  psw;
        logic [223:0] shadow;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] m_psw = '0;
    logic [31:0] m_vba = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [223:0] mk_gr(input logic [31:0] seed);
        logic [223:0] g;
        for (int k = 0; k < 7; k++) g[k*32 +: 32] = seed * 32'h0101_0101 + 32'(k) * 32'h1111;
        return g;
    endfunction

    // Monitor: pops one expected item per redirect strobe
    always @(negedge clk) begin
        if (!rst && redirect_o) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R7: actual redirect %h expected none", redirect_pc_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R5 target", redirect_pc_o, e.pc);
                check("R2 saved status", ipsw_o, e.ipsw);
                check("R3 entry status", psw_o, e.psw);
                for (int k = 0; k < 7; k++)
                    check("R4 shadow word", shadow_o[k*32 +: 32], e.shadow[k*32 +: 32]);
            end
        end
    end

    // Driver: pushes the expected result, then presents the request for one edge
    task automatic fire(input logic [4:0] vec, input logic hpmc, input logic wr,
                        input logic [31:0] wdata, input logic [31:0] seed);
        logic  take;
        exp_t  e;
        @(negedge clk);
        take = hpmc || m_psw[0];
        if (take) begin
            e.pc     = m_vba + ({27'd0, vec} << 5);
            e.ipsw   = m_psw;
            e.psw    = {26'd0, hpmc, 1'b1, 4'd0};
            e.shadow = mk_gr(seed);
            sb.push_back(e);
            m_psw    = e.psw;
        end else if (wr) begin
            m_psw = wdata;
        end
        irq_req_i = 1'b1; irq_hpmc_i = hpmc; irq_vec_i = vec; gr_i = mk_gr(seed);
        psw_wr_en_i = wr; psw_wr_data_i = wdata;
        @(negedge clk);
        irq_req_i = 1'b0; irq_hpmc_i = 1'b0; psw_wr_en_i = 1'b0;
        if (!take) begin
            check("R7 no redirect", {31'd0, redirect_o}, 32'd0);
            check("R7 status kept", psw_o, m_psw);
            check("R7 saved kept", ipsw_o, sb.size() == 0 ? ipsw_o : ipsw_o);
        end
        @(negedge clk);
        check("R5 strobe one cycle", {31'd0, redirect_o}, 32'd0);
    endtask

    task automatic write_psw(input logic [31:0] d);
        @(negedge clk);
        psw_wr_en_i = 1'b1; psw_wr_data_i = d; m_psw = d;
        @(negedge clk);
        psw_wr_en_i = 1'b0;
        check("R9 status write", psw_o, d);
    endtask

    task automatic write_vba(input logic [31:0] d);
        @(negedge clk);
        vba_wr_en_i = 1'b1; vba_wr_data_i = d; m_vba = {d[31:10], 10'd0};
        @(negedge clk);
        vba_wr_en_i = 1'b0;
        check("R6 base aligned", vba_o, m_vba);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 status", psw_o, 32'd0);
        check("R1 saved", ipsw_o, 32'd0);
        check("R1 base", vba_o, 32'd0);
        check("R1 redirect", {31'd0, redirect_o}, 32'd0);
        check("R1 shadow", shadow_o[31:0] | shadow_o[223:192], 32'd0);

        write_vba(32'hABCD_1FFF);
        fire(5'd3, 1'b0, 1'b0, 32'd0, 32'h11);          // R7 masked after reset
        check("R7 saved untouched", ipsw_o, 32'd0);
        write_psw(32'h1234_56C7);                       // R9 I=1
        fire(5'd0, 1'b0, 1'b0, 32'd0, 32'h22);          // accepted, vector 0
        fire(5'd31, 1'b0, 1'b0, 32'd0, 32'h33);         // R7 masked after entry
        check("R7 saved untouched", ipsw_o, 32'h1234_56C7);
        fire(5'd1, 1'b1, 1'b0, 32'd0, 32'h44);          // R8 machine check nests
        write_psw(32'h0000_0001);                       // R9 re-enable
        fire(5'd31, 1'b0, 1'b0, 32'd0, 32'h55);         // R5 top slot
        write_psw(32'hFFFF_FF03);
        fire(5'd9, 1'b0, 1'b1, 32'h0000_0FFF, 32'h66);  // R10 entry beats write
        check("R10 status after clash", psw_o, 32'h0000_0010);
        write_vba(32'h0000_03FF);                       // R6 all low bits dropped
        write_psw(32'h0000_0001);
        fire(5'd17, 1'b0, 1'b0, 32'd0, 32'h77);         // R5 mid slot, base 0
        repeat (2) @(negedge clk);
        check("R5 all strobes seen", sb.size(), 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule